// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Locks

This block is the tag side of a set-associative cache. For every set and way it holds a line address, a permission code and an optional lock owner. The data array, the coherence protocol and any statistics live elsewhere. A controller sends one command per request: lookup, availability query, allocate, deallocate, victim probe, permission write, lock set, lock clear or lock test. The answer comes back on the next clock edge.

A line counts as present only when its stored address matches and its permission is not the not-present code. A way that is empty or not-present can take a new line. Each set keeps true-LRU age counters, and the victim way is chosen from them. The number of sets is the cache capacity divided by the associativity and then by the line size. The set index starts at a configurable address bit.

Top module: `tdir_top`

## Requirements
- R1: After reset no response is pending. Every way of every set is empty, so a lookup misses and the availability flag is 1.
- R2: The set is `addr_i[IDX_LSB +: SET_W]`, with SETS = CACHE_BYTES / WAYS / LINE_BYTES and SET_W = log2(SETS). A line is found only by its full address within its own set.
- R3: Permission codes are 0 not-present, 1 invalid, 2 read-only, 3 read-write and 4 busy. A lookup hits only when a way holds the address with a nonzero code. `hit_way_o` gives the lowest such way. A lookup never sets `err_o`.
- R4: `avail_o` is 1 when a way of the set holds the address, whatever its code, or when a way is empty or has code 0.
- R5: A successful allocate fills the lowest empty or code-0 way. It stores the address, sets code 1 and leaves the line unlocked.
- R6: An allocate fails when the address already hits or the set has no free way. It then sets `err_o` and changes nothing.
- R7: A deallocate of a hitting line empties its way. A deallocate that misses sets `err_o`.
- R8: A permission write stores `perm_i` into the lowest way holding the address, whatever that way's current code. If no way holds the address, it sets `err_o`.
- R9: Two commands refresh a way: a lookup hit with `touch_i` refreshes the hit way, and a successful allocate with `touch_i` refreshes the filled way. The victim is the least recently refreshed way. After reset the victim is the highest way. `victim_addr_o` is the address stored in the victim way. A probe sets `err_o` when `avail_o` would be 1.
- R10: Lock set records `ctx_i` on a hitting line, and lock clear removes the owner. Lock test gives 1 only for a hitting, locked line whose owner equals `ctx_i`. A lock command that misses sets `err_o`.
- R11: `req_ready_o` is always 1. Every accepted request produces `rsp_valid_o` for exactly one cycle on the next clock. While `rsp_valid_o` is low, `hit_o`, `lock_o` and `err_o` are 0.
- R12: Command codes on `cmd_i` are 0 lookup, 1 availability, 2 allocate, 3 deallocate, 4 probe, 5 permission write, 6 lock set, 7 lock clear and 8 lock test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Request accepted (always 1) |
| cmd_i | input | 4 | Command code |
| addr_i | input | ADDR_W | Line-aligned address |
| touch_i | input | 1 | Refresh recency on a lookup hit or allocate |
| perm_i | input | 3 | Permission code for a permission write |
| ctx_i | input | CTX_W | Lock context |
| rsp_valid_o | output | 1 | Response strobe |
| hit_o | output | 1 | Address present with nonzero code |
| hit_way_o | output | log2(WAYS) | Lowest hitting way |
| avail_o | output | 1 | A way can hold the address |
| victim_addr_o | output | ADDR_W | Address stored in the LRU way |
| lock_o | output | 1 | Lock test result |
| err_o | output | 1 | Command could not be applied |

## Verification
The hardest state to reach is a full set whose LRU order is known, with some ways revived from the not-present code. The probe, the full-set allocate error and the refresh logic all depend on that state. The directed part fills one set completely with touched allocates, then reorders recency with touched lookups, and demotes and revives a way through permission writes. A long pseudo-random run follows. It uses only four tags per set, so full sets, duplicate allocates and lock collisions happen often, and a bench model predicts every response.

// File: rtl/tdir_pkg.sv
package tdir_pkg;
  typedef enum logic [3:0] {
    CMD_LOOKUP = 4'd0, CMD_AVAIL = 4'd1, CMD_ALLOC = 4'd2, CMD_DEALLOC = 4'd3,
    CMD_PROBE = 4'd4, CMD_PERM = 4'd5, CMD_LK_SET = 4'd6, CMD_LK_CLR = 4'd7,
    CMD_LK_TEST = 4'd8
  } cmd_e;

  localparam logic [2:0] PERM_NP  = 3'd0;
  localparam logic [2:0] PERM_INV = 3'd1;
endpackage

// File: rtl/tdir_set_match.sv
module tdir_set_match #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]   vld_i,
  input  logic [2:0]        perm_i [WAYS],
  input  logic [ADDR_W-1:0] line_i [WAYS],
  input  logic [ADDR_W-1:0] addr_i,
  output logic              tag_any_o,
  output logic [WAY_W-1:0]  tag_way_o,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic              free_any_o,
  output logic [WAY_W-1:0]  free_way_o
);
  logic [WAYS-1:0] tag_v, hit_v, free_v;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tag_v[w]  = vld_i[w] && (line_i[w] == addr_i);
    assign hit_v[w]  = tag_v[w] && (perm_i[w] != tdir_pkg::PERM_NP);
    assign free_v[w] = !vld_i[w] || (perm_i[w] == tdir_pkg::PERM_NP);
  end

  // lowest index wins
  always_comb begin
    tag_way_o  = '0;
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (tag_v[w])  tag_way_o  = WAY_W'(w);
      if (hit_v[w])  hit_way_o  = WAY_W'(w);
      if (free_v[w]) free_way_o = WAY_W'(w);
    end
  end

  assign tag_any_o  = |tag_v;
  assign hit_o      = |hit_v;
  assign free_any_o = |free_v;
endmodule

// File: rtl/tdir_lru.sv
module tdir_lru #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] set_i,
  output logic [WAY_W-1:0] victim_way_o
);
  // age 0 = most recent, WAYS-1 = victim; ages form a permutation per set
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[set_i][w] == WAY_W'(WAYS - 1)) victim_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/tdir_top.sv
module tdir_top #(
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 128,
  parameter int LINE_BYTES  = 4,
  parameter int WAYS        = 4,
  parameter int IDX_LSB     = $clog2(LINE_BYTES),
  parameter int CTX_W       = 4,
  localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              touch_i,
  input  logic [2:0]        perm_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic              avail_o,
  output logic [ADDR_W-1:0] victim_addr_o,
  output logic              lock_o,
  output logic              err_o
);
  import tdir_pkg::*;

  logic [WAYS-1:0]   vld_q [SETS];
  logic [2:0]        perm_q [SETS][WAYS];
  logic [ADDR_W-1:0] line_q [SETS][WAYS];
  logic              lk_q [SETS][WAYS];
  logic [CTX_W-1:0]  own_q [SETS][WAYS];

  cmd_e              cmd;
  logic [SET_W-1:0]  set_idx;
  logic [2:0]        row_perm [WAYS];
  logic [ADDR_W-1:0] row_line [WAYS];
  logic              tag_any, hit, free_any, avail, err_c, lock_c, alloc_ok, touch_en;
  logic [WAY_W-1:0]  tag_way, hit_way, free_way, vic_way, touch_way;

  assign cmd         = cmd_e'(cmd_i);
  assign set_idx     = addr_i[IDX_LSB +: SET_W];
  assign req_ready_o = 1'b1;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      row_perm[w] = perm_q[set_idx][w];
      row_line[w] = line_q[set_idx][w];
    end
  end

  tdir_set_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
    .vld_i(vld_q[set_idx]), .perm_i(row_perm), .line_i(row_line), .addr_i(addr_i),
    .tag_any_o(tag_any), .tag_way_o(tag_way), .hit_o(hit), .hit_way_o(hit_way),
    .free_any_o(free_any), .free_way_o(free_way)
  );

  assign avail    = tag_any | free_any;
  assign alloc_ok = req_valid_i && (cmd == CMD_ALLOC) && !hit && free_any;
  assign touch_en = req_valid_i && touch_i && (((cmd == CMD_LOOKUP) && hit) || alloc_ok);
  assign touch_way = (cmd == CMD_ALLOC) ? free_way : hit_way;

  tdir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch_en), .touch_set_i(set_idx),
    .touch_way_i(touch_way), .set_i(set_idx), .victim_way_o(vic_way)
  );

  always_comb begin
    unique case (cmd)
      CMD_ALLOC:                            err_c = hit || !free_any;
      CMD_DEALLOC, CMD_LK_SET, CMD_LK_CLR,
      CMD_LK_TEST:                          err_c = !hit;
      CMD_PERM:                             err_c = !tag_any;
      CMD_PROBE:                            err_c = avail;
      default:                              err_c = 1'b0;
    endcase
  end

  assign lock_c = (cmd == CMD_LK_TEST) && hit && lk_q[set_idx][hit_way] &&
                  (own_q[set_idx][hit_way] == ctx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          perm_q[s][w] <= PERM_NP;
          line_q[s][w] <= '0;
          lk_q[s][w]   <= 1'b0;
          own_q[s][w]  <= '0;
        end
      end
    end else if (req_valid_i && !err_c) begin
      unique case (cmd)
        CMD_ALLOC: begin
          vld_q[set_idx][free_way]  <= 1'b1;
          line_q[set_idx][free_way] <= addr_i;
          perm_q[set_idx][free_way] <= PERM_INV;
          lk_q[set_idx][free_way]   <= 1'b0;
        end
        CMD_DEALLOC: vld_q[set_idx][hit_way]  <= 1'b0;
        CMD_PERM:    perm_q[set_idx][tag_way] <= perm_i;
        CMD_LK_SET: begin
          lk_q[set_idx][hit_way]  <= 1'b1;
          own_q[set_idx][hit_way] <= ctx_i;
        end
        CMD_LK_CLR:  lk_q[set_idx][hit_way] <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      hit_o         <= 1'b0;
      hit_way_o     <= '0;
      avail_o       <= 1'b0;
      victim_addr_o <= '0;
      lock_o        <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      hit_o         <= req_valid_i && hit;
      hit_way_o     <= hit_way;
      avail_o       <= req_valid_i && avail;
      victim_addr_o <= line_q[set_idx][vic_way];
      lock_o        <= req_valid_i && lock_c;
      err_o         <= req_valid_i && err_c;
    end
  end
endmodule

// File: rtl/tdir_chk.sv
module tdir_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [3:0] cmd_i,
  input logic       rsp_valid_o,
  input logic       hit_o,
  input logic       avail_o,
  input logic       lock_o,
  input logic       err_o
);
  a_r11_rsp_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r11_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(hit_o || lock_o || err_o));
  a_r4_hit_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && hit_o) |-> avail_o);
  a_r10_lock_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> hit_o);
  a_r6_alloc_dup_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cmd_i == 4'd2) |=> (!hit_o || err_o));
  a_r3_lookup_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cmd_i == 4'd0) |=> !err_o);
  a_r9_probe_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cmd_i == 4'd4) |=> (err_o == avail_o));
endmodule

bind tdir_top tdir_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .cmd_i(cmd_i),
  .rsp_valid_o(rsp_valid_o), .hit_o(hit_o), .avail_o(avail_o), .lock_o(lock_o),
  .err_o(err_o)
);

// File: tb/tb_tdir_top.sv
module tb_tdir_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int WAYS = 4;
  localparam int SETS = 8;
  localparam int IDX_LSB = 2;
  localparam int CTX_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, touch = 1'b0;
  logic [3:0] cmd = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [2:0] perm = '0;
  logic [CTX_W-1:0] ctx = '0;
  logic rdy, rsp_valid, hit, avail, lock, err;
  logic [1:0] hit_way;
  logic [ADDR_W-1:0] victim;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  bit          m_vld [SETS][WAYS];
  logic [ADDR_W-1:0] m_line [SETS][WAYS];
  int          m_perm [SETS][WAYS];
  bit          m_lk [SETS][WAYS];
  int          m_own [SETS][WAYS];
  int          m_age [SETS][WAYS];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdir_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(rdy),
    .cmd_i(cmd), .addr_i(addr), .touch_i(touch), .perm_i(perm), .ctx_i(ctx),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .hit_way_o(hit_way), .avail_o(avail),
    .victim_addr_o(victim), .lock_o(lock), .err_o(err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tg, input int s);
    return ADDR_W'((tg << 5) | (s << IDX_LSB));
  endfunction

  task automatic touch_m(input int s, input int w);
    int a0 = m_age[s][w];
    for (int k = 0; k < WAYS; k++)
      if (k == w) m_age[s][k] = 0;
      else if (m_age[s][k] < a0) m_age[s][k]++;
  endtask

  // one request; expected values from the bench model, model then updated
  task automatic op(input string tag, input int c, input logic [ADDR_W-1:0] a,
                    input bit t, input int p, input int cx);
    int s = int'(a[IDX_LSB +: 3]);
    bit e_hit = 0, e_tany = 0, e_fany = 0, e_err = 0, e_lock = 0;
    int e_hw = 0, e_tw = 0, e_fw = 0, e_vw = 0;
    string et;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (m_vld[s][w] && m_line[s][w] == a) begin
        e_tany = 1; e_tw = w;
        if (m_perm[s][w] != 0) begin e_hit = 1; e_hw = w; end
      end
      if (!m_vld[s][w] || m_perm[s][w] == 0) begin e_fany = 1; e_fw = w; end
      if (m_age[s][w] == WAYS - 1) e_vw = w;
    end
    case (c)
      2: begin e_err = e_hit || !e_fany; et = "R6"; end
      3: begin e_err = !e_hit; et = "R7"; end
      4: begin e_err = e_tany || e_fany; et = "R9"; end
      5: begin e_err = !e_tany; et = "R8"; end
      6, 7, 8: begin e_err = !e_hit; et = "R10"; end
      default: begin e_err = 0; et = "R3"; end
    endcase
    e_lock = (c == 8) && e_hit && m_lk[s][e_hw] && m_own[s][e_hw] == cx;
    req_valid = 1; cmd = 4'(c); addr = a; touch = t; perm = 3'(p); ctx = CTX_W'(cx);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check({tag, " R11 rsp_valid"}, 32'(rsp_valid), 1);
    check({tag, " R3 hit"}, 32'(hit), 32'(e_hit));
    if (e_hit) check({tag, " R3 hit_way"}, 32'(hit_way), 32'(e_hw));
    check({tag, " R4 avail"}, 32'(avail), 32'(e_tany || e_fany));
    check({tag, " R9 victim"}, 32'(victim), 32'(m_line[s][e_vw]));
    check({tag, " R10 lock"}, 32'(lock), 32'(e_lock));
    check({tag, " ", et, " err"}, 32'(err), 32'(e_err));
    if (!e_err) begin
      case (c)
        0: if (t && e_hit) touch_m(s, e_hw);
        2: begin
          m_vld[s][e_fw] = 1; m_line[s][e_fw] = a; m_perm[s][e_fw] = 1; m_lk[s][e_fw] = 0;
          if (t) touch_m(s, e_fw);
        end
        3: m_vld[s][e_hw] = 0;
        5: m_perm[s][e_tw] = p;
        6: begin m_lk[s][e_hw] = 1; m_own[s][e_hw] = cx; end
        7: m_lk[s][e_hw] = 0;
        default: ;
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 40000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_line[s][w] = '0; m_perm[s][w] = 0;
        m_lk[s][w] = 0; m_own[s][w] = 0; m_age[s][w] = w;
      end
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", 32'(rsp_valid), 0);
    check("R1 reset err", 32'(err), 0);
    rst_ni = 1;
    @(negedge clk);
    check("R11 ready", 32'(rdy), 1);
    for (int s = 0; s < SETS; s++) op("R1 empty", 0, mk(1, s), 1, 0, 0);
    // R2: same tag different set, different tag same set
    op("R2 alloc", 2, mk(1, 3), 0, 0, 0);
    op("R2 other set", 0, mk(1, 4), 0, 0, 0);
    op("R2 other tag", 0, mk(2, 3), 0, 0, 0);
    op("R2 same", 0, mk(1, 3), 0, 0, 0);
    // R5/R6/R9: fill set 0, reorder recency, probe
    op("R9 reset victim", 4, mk(0, 0), 0, 0, 0);
    for (int tg = 0; tg < WAYS; tg++) op("R5 fill", 2, mk(tg, 0), 1, 0, 0);
    op("R6 full", 2, mk(7, 0), 1, 0, 0);
    op("R6 dup", 2, mk(2, 0), 1, 0, 0);
    op("R9 probe full", 4, mk(7, 0), 0, 0, 0);
    op("R9 touch", 0, mk(0, 0), 1, 0, 0);
    op("R9 touch", 0, mk(1, 0), 1, 0, 0);
    op("R9 probe", 4, mk(7, 0), 0, 0, 0);
    op("R9 no touch", 0, mk(2, 0), 0, 0, 0);
    op("R9 probe", 4, mk(7, 0), 0, 0, 0);
    // R3/R8/R5: demote way 1 to not-present, reuse it, revive
    op("R8 perm np", 5, mk(1, 0), 0, 0, 0);
    op("R3 np miss", 0, mk(1, 0), 1, 0, 0);
    op("R4 np avail", 1, mk(7, 0), 0, 0, 0);
    op("R8 revive", 5, mk(1, 0), 0, 3, 0);
    op("R3 revived", 0, mk(1, 0), 0, 0, 0);
    op("R8 np again", 5, mk(1, 0), 0, 0, 0);
    op("R5 reuse np", 2, mk(5, 0), 1, 0, 0);
    op("R8 miss", 5, mk(6, 0), 0, 2, 0);
    // R10 locks
    op("R10 set", 6, mk(5, 0), 0, 0, 9);
    op("R10 test eq", 8, mk(5, 0), 0, 0, 9);
    op("R10 test ne", 8, mk(5, 0), 0, 0, 3);
    op("R10 clr", 7, mk(5, 0), 0, 0, 0);
    op("R10 test clr", 8, mk(5, 0), 0, 0, 9);
    op("R10 miss", 6, mk(6, 0), 0, 0, 1);
    // R7 dealloc
    op("R7 dealloc", 3, mk(3, 0), 0, 0, 0);
    op("R7 gone", 0, mk(3, 0), 0, 0, 0);
    op("R7 again", 3, mk(3, 0), 0, 0, 0);
    op("R12 bad code", 15, mk(5, 0), 1, 0, 0);
    // near-exhaustive: every set with every tag, then random mix
    for (int s = 0; s < SETS; s++)
      for (int tg = 0; tg < 5; tg++) op("R5 sweep", 2, mk(tg, s), tg[0], 0, 0);
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op("R12 mix", int'(lf[3:0]) % 9, mk(int'(lf[5:4]), int'(lf[8:6])),
         lf[9], int'(lf[12:10]) % 5, int'(lf[15:14]));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule